// File: doc/BRIEF.md
# Interval Timer Register Front End

This block is the bus-facing register layer of a three-channel interval timer. A host uses an 8-bit data bus and a 2-bit address. Addresses 0 to 2 reach the data ports of the three counting channels, and address 3 is the command port. Command bytes written to the command port do one of three things. They can program a channel's counting mode, BCD flag and byte access format. They can freeze one channel's present count. They can issue a combined read-back that freezes the count and/or the status of any set of channels at once.

Count bytes written to a channel port are assembled according to that channel's stored format. The assembled 16-bit value is handed to the channel with a one-cycle load strobe. Reads of a channel port return either a frozen snapshot or the live count, byte by byte in the stored format, so a latched value can be read while the channel keeps counting. The counting channels sit outside this block. They supply their live counts, output levels and a pulse saying a loaded value was taken.

The bus has no back-pressure: every write or read strobe is accepted in the cycle it is presented. Read data is combinational from the address during the read strobe. Any byte-pointer or latch-release effect of a read takes place at the clock edge that ends the strobe. Writes take effect at the clock edge that ends the strobe. Registered outputs show the result from the following cycle.

Top module: `tmr_regs_front`

## Requirements
- R1: A command byte whose bits 7:6 hold 0, 1 or 2 and whose bits 5:4 are nonzero programs that channel. Bits 5:4 become the access format (01 high byte only, 10 low byte only, 11 low then high). Bits 3:1 become the mode and bit 0 the BCD flag. From the next cycle the channel's mode and BCD outputs show the new values, and its config strobe is high for one cycle.
- R2: In the high-only format, a data byte written to a channel port loads {byte, 8'h00}. In the low-only format, it loads {8'h00, byte}. The load strobe is high for exactly one cycle, the cycle after the write.
- R3: In the low-then-high format, the first data byte is held and produces no load strobe. The second byte produces a load of {second, first}.
- R4: Programming a channel returns both its write and read byte pointers to the low byte and discards any pending count or status latch.
- R5: A command with bits 5:4 = 00 freezes the selected channel's count as it stood at that write. Reads then return the frozen bytes while the live count keeps changing. The freeze is released once it has been read out completely in the channel's format: one read for single-byte formats, two reads for low-then-high.
- R6: A count freeze request for a channel that already holds an unread frozen count is ignored.
- R7: A command with bits 7:6 = 11 and bit 0 = 0 is a read-back. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 = 0 freezes their counts and bit 4 = 0 freezes their status. A latch that is already pending is kept.
- R8: A read-back command with bit 0 = 1 has no effect.
- R9: The status byte holds, from bit 7 down: the channel output level, the null-count flag, the two format bits, the three mode bits and the BCD flag.
- R10: When status is pending, the next read of that channel returns the status byte. Following reads return the frozen count bytes if a count is pending, otherwise the live count.
- R11: A channel's null-count flag is 1 after reset, is set by programming the channel and by each load strobe, and is cleared by the channel's taken pulse. A set in the same cycle wins over a clear.
- R12: With nothing pending, reads return the live count. In the low-then-high format, reads alternate low byte and high byte, starting with the low byte.
- R13: A read of address 3 returns 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_rd | input | 1 | Read strobe, one byte per cycle |
| bus_addr | input | 2 | 0-2 channel data ports, 3 command port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| ch_load_stb | output | 3 | Per-channel one-cycle load strobe |
| ch_load_val | output | 48 | Per-channel 16-bit value to load, channel n at bits 16n+15:16n |
| ch_cfg_stb | output | 3 | Per-channel one-cycle strobe after programming |
| ch_mode | output | 9 | Per-channel 3-bit mode, channel n at bits 3n+2:3n |
| ch_bcd | output | 3 | Per-channel BCD flag |
| ch_count | input | 48 | Per-channel live count from the counting channels |
| ch_out | input | 3 | Per-channel output level |
| ch_taken | input | 3 | Per-channel pulse: loaded value was taken into the counter |

## Verification
The checker relies on the host never raising the write and read strobes in the same cycle. It also relies on the address always naming one of the four ports. Under these conditions every load and config strobe traces back to exactly one write in the previous cycle. The bench keeps within these conditions because it drives every access through one task per operation. Each task raises one strobe for one cycle at a falling edge and never overlaps accesses. The taken pulse is only ever raised by itself, so a set and a clear of the null flag never collide except where a check intends it.

// File: rtl/tmr_fe_pkg.sv
package tmr_fe_pkg;

  typedef enum logic [1:0] {
    ACC_FREEZE = 2'b00,
    ACC_HIGH   = 2'b01,
    ACC_LOW    = 2'b10,
    ACC_PAIR   = 2'b11
  } acc_fmt_e;

  // Bit order matches command bits 5:0 so a cast picks the fields out.
  typedef struct packed {
    acc_fmt_e   fmt;
    logic [2:0] mode;
    logic       bcd;
  } ch_cfg_t;

  localparam ch_cfg_t CFG_RESET = '{fmt: ACC_PAIR, mode: 3'd0, bcd: 1'b0};

  function automatic logic [7:0] pack_status(logic lvl, logic nul, ch_cfg_t c);
    return {lvl, nul, c};
  endfunction

endpackage

// File: rtl/tmr_fe_decode.sv
module tmr_fe_decode #(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [NUM_CH-1:0] cfg_we,
  output logic [NUM_CH-1:0] frz_cnt,
  output logic [NUM_CH-1:0] frz_sts,
  output logic [NUM_CH-1:0] dat_wr,
  output logic [NUM_CH-1:0] dat_rd
);

  localparam logic [ADDR_W-1:0] CMD_ADDR = ADDR_W'(NUM_CH);

  logic       cmd_wr;
  logic [1:0] sel;
  logic [1:0] acc;
  logic       is_rb;
  logic       rb_ok;

  assign cmd_wr = bus_wr && (bus_addr == CMD_ADDR);
  assign sel    = bus_wdata[7:6];
  assign acc    = bus_wdata[5:4];
  assign is_rb  = (sel == 2'b11);
  assign rb_ok  = cmd_wr && is_rb && !bus_wdata[0];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic hit;
    assign hit        = cmd_wr && !is_rb && (sel == 2'(i));
    assign cfg_we[i]  = hit && (acc != 2'b00);
    assign frz_cnt[i] = (hit && (acc == 2'b00)) ||
                        (rb_ok && bus_wdata[i+1] && !bus_wdata[5]);
    assign frz_sts[i] = rb_ok && bus_wdata[i+1] && !bus_wdata[4];
    assign dat_wr[i]  = bus_wr && (bus_addr == ADDR_W'(i));
    assign dat_rd[i]  = bus_rd && (bus_addr == ADDR_W'(i));
  end

endmodule

// File: rtl/tmr_fe_chan.sv
module tmr_fe_chan
  import tmr_fe_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [5:0]        cfg_bits,
  input  logic              frz_cnt,
  input  logic              frz_sts,
  input  logic              dat_wr,
  input  logic              dat_rd,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  live_cnt,
  input  logic              out_lvl,
  input  logic              taken,
  output logic              load_stb,
  output logic [CNT_W-1:0]  load_val,
  output logic              cfg_stb,
  output logic [2:0]        mode,
  output logic              bcd,
  output logic              null_cnt,
  output logic [DATA_W-1:0] rd_byte
);

  localparam int HI_LSB = CNT_W - DATA_W;

  ch_cfg_t           cfg_q;
  logic              wr_hi_q;
  logic              rd_hi_q;
  logic [DATA_W-1:0] low_hold_q;
  logic [CNT_W-1:0]  cnt_snap_q;
  logic              cnt_pend_q;
  logic [7:0]        sts_snap_q;
  logic              sts_pend_q;
  logic              null_q;
  logic              load_stb_q;
  logic [CNT_W-1:0]  load_val_q;
  logic              cfg_stb_q;

  logic [CNT_W-1:0]  cnt_src;
  logic [DATA_W-1:0] src_lo;
  logic [DATA_W-1:0] src_hi;

  assign cnt_src = cnt_pend_q ? cnt_snap_q : live_cnt;
  assign src_lo  = cnt_src[DATA_W-1:0];
  assign src_hi  = cnt_src[CNT_W-1:HI_LSB];

  always_comb begin
    if (sts_pend_q) begin
      rd_byte = sts_snap_q;
    end else begin
      unique case (cfg_q.fmt)
        ACC_HIGH: rd_byte = src_hi;
        ACC_LOW:  rd_byte = src_lo;
        ACC_PAIR: rd_byte = rd_hi_q ? src_hi : src_lo;
        default:  rd_byte = src_lo;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q      <= CFG_RESET;
      wr_hi_q    <= 1'b0;
      rd_hi_q    <= 1'b0;
      low_hold_q <= '0;
      cnt_snap_q <= '0;
      cnt_pend_q <= 1'b0;
      sts_snap_q <= '0;
      sts_pend_q <= 1'b0;
      null_q     <= 1'b1;
      load_stb_q <= 1'b0;
      load_val_q <= '0;
      cfg_stb_q  <= 1'b0;
    end else begin
      load_stb_q <= 1'b0;
      cfg_stb_q  <= cfg_we;
      if (cfg_we) begin
        cfg_q      <= ch_cfg_t'(cfg_bits);
        wr_hi_q    <= 1'b0;
        rd_hi_q    <= 1'b0;
        cnt_pend_q <= 1'b0;
        sts_pend_q <= 1'b0;
        null_q     <= 1'b1;
      end else begin
        if (taken) null_q <= 1'b0;
        if (dat_wr) begin
          unique case (cfg_q.fmt)
            ACC_HIGH: begin
              load_val_q <= {wdata, {DATA_W{1'b0}}};
              load_stb_q <= 1'b1;
              null_q     <= 1'b1;
            end
            ACC_LOW: begin
              load_val_q <= {{DATA_W{1'b0}}, wdata};
              load_stb_q <= 1'b1;
              null_q     <= 1'b1;
            end
            default: begin
              if (!wr_hi_q) begin
                low_hold_q <= wdata;
                wr_hi_q    <= 1'b1;
              end else begin
                load_val_q <= {wdata, low_hold_q};
                load_stb_q <= 1'b1;
                null_q     <= 1'b1;
                wr_hi_q    <= 1'b0;
              end
            end
          endcase
        end
        if (dat_rd) begin
          if (sts_pend_q) begin
            sts_pend_q <= 1'b0;
          end else if (cfg_q.fmt == ACC_PAIR) begin
            rd_hi_q <= !rd_hi_q;
            if (rd_hi_q) cnt_pend_q <= 1'b0;
          end else begin
            cnt_pend_q <= 1'b0;
          end
        end
        if (frz_cnt && !cnt_pend_q) begin
          cnt_snap_q <= live_cnt;
          cnt_pend_q <= 1'b1;
        end
        if (frz_sts && !sts_pend_q) begin
          sts_snap_q <= pack_status(out_lvl, null_q, cfg_q);
          sts_pend_q <= 1'b1;
        end
      end
    end
  end

  assign load_stb = load_stb_q;
  assign load_val = load_val_q;
  assign cfg_stb  = cfg_stb_q;
  assign mode     = cfg_q.mode;
  assign bcd      = cfg_q.bcd;
  assign null_cnt = null_q;

endmodule

// File: rtl/tmr_fe_rdmux.sv
module tmr_fe_rdmux #(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic [ADDR_W-1:0]        addr,
  input  logic [NUM_CH*DATA_W-1:0] bytes_in,
  output logic [DATA_W-1:0]        rdata
);

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr == ADDR_W'(i)) rdata = bytes_in[i*DATA_W +: DATA_W];
    end
  end

endmodule

// File: rtl/tmr_regs_front.sv
module tmr_regs_front #(
  parameter int NUM_CH = 3,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  output logic [NUM_CH-1:0]        ch_load_stb,
  output logic [NUM_CH*CNT_W-1:0]  ch_load_val,
  output logic [NUM_CH-1:0]        ch_cfg_stb,
  output logic [NUM_CH*3-1:0]      ch_mode,
  output logic [NUM_CH-1:0]        ch_bcd,
  input  logic [NUM_CH*CNT_W-1:0]  ch_count,
  input  logic [NUM_CH-1:0]        ch_out,
  input  logic [NUM_CH-1:0]        ch_taken
);

  logic [NUM_CH-1:0]        cfg_we;
  logic [NUM_CH-1:0]        frz_cnt;
  logic [NUM_CH-1:0]        frz_sts;
  logic [NUM_CH-1:0]        dat_wr;
  logic [NUM_CH-1:0]        dat_rd;
  logic [NUM_CH-1:0]        null_vec;
  logic [NUM_CH*DATA_W-1:0] rd_bytes;

  tmr_fe_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cfg_we    (cfg_we),
    .frz_cnt   (frz_cnt),
    .frz_sts   (frz_sts),
    .dat_wr    (dat_wr),
    .dat_rd    (dat_rd)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    tmr_fe_chan #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we[i]),
      .cfg_bits (bus_wdata[5:0]),
      .frz_cnt  (frz_cnt[i]),
      .frz_sts  (frz_sts[i]),
      .dat_wr   (dat_wr[i]),
      .dat_rd   (dat_rd[i]),
      .wdata    (bus_wdata),
      .live_cnt (ch_count[i*CNT_W +: CNT_W]),
      .out_lvl  (ch_out[i]),
      .taken    (ch_taken[i]),
      .load_stb (ch_load_stb[i]),
      .load_val (ch_load_val[i*CNT_W +: CNT_W]),
      .cfg_stb  (ch_cfg_stb[i]),
      .mode     (ch_mode[i*3 +: 3]),
      .bcd      (ch_bcd[i]),
      .null_cnt (null_vec[i]),
      .rd_byte  (rd_bytes[i*DATA_W +: DATA_W])
    );
  end

  tmr_fe_rdmux #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rdmux (
    .addr     (bus_addr),
    .bytes_in (rd_bytes),
    .rdata    (bus_rdata)
  );

endmodule

// File: rtl/tmr_regs_front_chk.sv
module tmr_regs_front_chk #(
  parameter int NUM_CH = 3,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NUM_CH-1:0] ch_load_stb,
  input logic [NUM_CH-1:0] ch_cfg_stb,
  input logic [NUM_CH*3-1:0] ch_mode,
  input logic [NUM_CH-1:0] null_vec
);

  localparam logic [ADDR_W-1:0] CMD_ADDR = ADDR_W'(NUM_CH);

  // R2: strobes from different channels never coincide.
  p_single_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_load_stb));

  // R13: the command port reads as zero.
  p_cmd_reads_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == CMD_ADDR) |-> (bus_rdata == '0));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R1: a config strobe follows a programming write to that channel.
    p_cfg_from_cmd_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ch_cfg_stb[i] |-> $past(bus_wr && bus_addr == CMD_ADDR &&
                              bus_wdata[7:6] == 2'(i) && bus_wdata[5:4] != 2'b00));

    // R1: the mode output only moves together with a config strobe.
    p_mode_moves_with_cfg_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_cfg_stb[i] |-> $stable(ch_mode[i*3 +: 3]));

    // R2: a load strobe follows a data write to that channel.
    p_load_from_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ch_load_stb[i] |-> $past(bus_wr && bus_addr == ADDR_W'(i)));

    // R11: programming or loading leaves the null-count flag set.
    p_null_after_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_cfg_stb[i] || ch_load_stb[i]) |-> null_vec[i]);
  end

endmodule

bind tmr_regs_front tmr_regs_front_chk #(
  .NUM_CH (NUM_CH),
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_wr      (bus_wr),
  .bus_rd      (bus_rd),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .ch_load_stb (ch_load_stb),
  .ch_cfg_stb  (ch_cfg_stb),
  .ch_mode     (ch_mode),
  .null_vec    (null_vec)
);

// File: tb/test_tmr_regs_front.sv
module test_tmr_regs_front;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [7:0]  bus_wdata = 8'd0;
  logic [7:0]  bus_rdata;
  logic [2:0]  ch_load_stb;
  logic [47:0] ch_load_val;
  logic [2:0]  ch_cfg_stb;
  logic [8:0]  ch_mode;
  logic [2:0]  ch_bcd;
  logic [47:0] ch_count;
  logic [2:0]  ch_out = 3'b101;
  logic [2:0]  ch_taken = 3'b000;

  logic        run = 1'b0;
  logic [15:0] live [3];
  logic [15:0] snap [3];
  logic [15:0] rsnap [3];
  logic        done = 1'b0;
  int          n_chk = 0;
  int          n_fail = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    for (int k = 0; k < 3; k++) begin
      if (!rst_n) live[k] <= 16'h1357 + 16'h2222 * 16'(k);
      else if (run) live[k] <= live[k] - 16'(k + 1);
    end
  end

  assign ch_count = {live[2], live[1], live[0]};

  tmr_regs_front i_tmr_regs_front (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .ch_load_stb (ch_load_stb),
    .ch_load_val (ch_load_val),
    .ch_cfg_stb  (ch_cfg_stb),
    .ch_mode     (ch_mode),
    .ch_bcd      (ch_bcd),
    .ch_count    (ch_count),
    .ch_out      (ch_out),
    .ch_taken    (ch_taken)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    for (int k = 0; k < 3; k++) snap[k] = live[k];
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] b);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    b = bus_rdata;
    for (int k = 0; k < 3; k++) rsnap[k] = live[k];
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] sts(input int c, input logic nul, input logic [1:0] f,
                                     input logic [2:0] m, input logic b);
    return {ch_out[c], nul, f, m, b};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] e0, e1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state
    chk("R2 reset load strobe", 16'(ch_load_stb), 16'h0);
    chk("R1 reset cfg strobe", 16'(ch_cfg_stb), 16'h0);
    chk("R1 reset mode", 16'(ch_mode), 16'h0);
    chk("R1 reset bcd", 16'(ch_bcd), 16'h0);
    wr(2'd3, 8'hEE);  // read-back status of all channels
    for (int c = 0; c < 3; c++) begin
      rd(2'(c), b);
      chk("R9 R11 reset status", 16'(b), 16'(sts(c, 1'b1, 2'b11, 3'd0, 1'b0)));
    end
    rd(2'd0, b); chk("R12 live low byte", 16'(b), 16'(live[0][7:0]));
    rd(2'd0, b); chk("R12 live high byte", 16'(b), 16'(live[0][15:8]));

    // Sweep of every programming word, checked through outputs and status
    for (int c = 0; c < 3; c++)
      for (int f = 1; f < 4; f++)
        for (int m = 0; m < 8; m++)
          for (int bc = 0; bc < 2; bc++) begin
            wr(2'd3, {2'(c), 2'(f), 3'(m), 1'(bc)});
            chk("R1 cfg strobe", 16'(ch_cfg_stb), 16'(1 << c));
            chk("R1 mode out", 16'(ch_mode[c*3 +: 3]), 16'(m));
            chk("R1 bcd out", 16'(ch_bcd[c]), 16'(bc));
            wr(2'd3, 8'hE0 | 8'(1 << (c + 1)));
            rd(2'(c), b);
            chk("R9 status layout", 16'(b), 16'(sts(c, 1'b1, 2'(f), 3'(m), 1'(bc))));
          end

    // Single-byte formats
    wr(2'd3, 8'b01_10_010_0);
    wr(2'd1, 8'h5A);
    chk("R2 low-only strobe", 16'(ch_load_stb), 16'b010);
    chk("R2 low-only value", ch_load_val[16 +: 16], 16'h005A);
    @(negedge clk);
    chk("R2 strobe one cycle", 16'(ch_load_stb), 16'h0);
    wr(2'd3, 8'b10_01_011_0);
    wr(2'd2, 8'hC3);
    chk("R2 high-only strobe", 16'(ch_load_stb), 16'b100);
    chk("R2 high-only value", ch_load_val[32 +: 16], 16'hC300);

    // Low then high
    wr(2'd3, 8'b00_11_000_0);
    wr(2'd0, 8'h34);
    chk("R3 no strobe after low", 16'(ch_load_stb), 16'h0);
    wr(2'd0, 8'h12);
    chk("R3 strobe after high", 16'(ch_load_stb), 16'b001);
    chk("R3 pair value", ch_load_val[0 +: 16], 16'h1234);

    // Programming resets the write pointer
    wr(2'd0, 8'hAA);
    wr(2'd3, 8'b00_11_000_0);
    wr(2'd0, 8'h78);
    chk("R4 pointer back to low", 16'(ch_load_stb), 16'h0);
    wr(2'd0, 8'h56);
    chk("R4 value after reprogram", ch_load_val[0 +: 16], 16'h5678);

    // Null-count flag
    @(negedge clk); ch_taken = 3'b001;
    @(negedge clk); ch_taken = 3'b000;
    wr(2'd3, 8'hE2);
    rd(2'd0, b); chk("R11 null cleared by taken", 16'(b), 16'(sts(0, 1'b0, 2'b11, 3'd0, 1'b0)));
    wr(2'd3, 8'b00_11_000_0);
    wr(2'd3, 8'hE2);
    rd(2'd0, b); chk("R11 null set by programming", 16'(b), 16'(sts(0, 1'b1, 2'b11, 3'd0, 1'b0)));

    // Frozen count while counting runs
    run = 1'b1;
    wr(2'd3, 8'b00_00_0000); e0 = snap[0];
    idle(5);
    rd(2'd0, b); chk("R5 frozen low", 16'(b), 16'(e0[7:0]));
    idle(3);
    rd(2'd0, b); chk("R5 frozen high", 16'(b), 16'(e0[15:8]));
    rd(2'd0, b); chk("R5 released low is live", 16'(b), 16'(rsnap[0][7:0]));
    rd(2'd0, b); chk("R12 released high is live", 16'(b), 16'(rsnap[0][15:8]));

    // Repeated freeze ignored
    wr(2'd3, 8'b00_00_0000); e0 = snap[0];
    idle(4);
    wr(2'd3, 8'b00_00_0000);
    rd(2'd0, b); chk("R6 first freeze kept low", 16'(b), 16'(e0[7:0]));
    rd(2'd0, b); chk("R6 first freeze kept high", 16'(b), 16'(e0[15:8]));

    // Freeze in high-only format releases after one read
    wr(2'd3, 8'b10_00_0000); e1 = snap[2];
    idle(3);
    rd(2'd2, b); chk("R5 frozen high-only", 16'(b), 16'(e1[15:8]));
    rd(2'd2, b); chk("R5 high-only released", 16'(b), 16'(rsnap[2][15:8]));

    // Read-back of count and status on two channels
    wr(2'd3, 8'b01_11_100_1);
    wr(2'd3, 8'hC6); e0 = snap[0]; e1 = snap[1];
    idle(4);
    rd(2'd1, b); chk("R10 ch1 status first", 16'(b), 16'(sts(1, 1'b1, 2'b11, 3'd4, 1'b1)));
    rd(2'd1, b); chk("R7 ch1 count low", 16'(b), 16'(e1[7:0]));
    rd(2'd1, b); chk("R7 ch1 count high", 16'(b), 16'(e1[15:8]));
    rd(2'd0, b); chk("R10 ch0 status first", 16'(b), 16'(sts(0, 1'b1, 2'b11, 3'd0, 1'b0)));
    rd(2'd0, b); chk("R7 ch0 count low", 16'(b), 16'(e0[7:0]));
    rd(2'd0, b); chk("R7 ch0 count high", 16'(b), 16'(e0[15:8]));
    rd(2'd2, b); chk("R7 unselected ch2 live", 16'(b), 16'(rsnap[2][15:8]));

    // Pending freeze survives a read-back count request
    wr(2'd3, 8'b01_00_0000); e1 = snap[1];
    idle(3);
    wr(2'd3, 8'hD4);
    rd(2'd1, b); chk("R7 pending kept low", 16'(b), 16'(e1[7:0]));
    rd(2'd1, b); chk("R7 pending kept high", 16'(b), 16'(e1[15:8]));

    // Read-back with bit 0 set does nothing
    run = 1'b0;
    wr(2'd3, 8'hC3);
    idle(3);
    rd(2'd0, b); chk("R8 ignored read-back low", 16'(b), 16'(live[0][7:0]));
    rd(2'd0, b); chk("R8 ignored read-back high", 16'(b), 16'(live[0][15:8]));

    // Status only, then live count
    wr(2'd3, 8'hE8);
    rd(2'd2, b); chk("R10 status-only", 16'(b), 16'(sts(2, 1'b1, 2'b01, 3'd3, 1'b0)));
    rd(2'd2, b); chk("R10 then live", 16'(b), 16'(live[2][15:8]));

    rd(2'd3, b); chk("R13 command port reads zero", 16'(b), 16'h0);

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule